// File: doc/BRIEF.md
# Streaming Wavelet Hard-Threshold Denoiser

This block removes small high-frequency disturbances from one channel of signed fixed-point samples. Every sample it accepts goes into a one-level orthogonal wavelet transform. A four-tap low-pass and high-pass filter pair runs at half the input rate and yields one low-band coefficient and one high-band coefficient for each pair of samples. The high-band coefficient then passes through a hard threshold. A synthesis filter pair, built from the same taps with the bands crossed over, rebuilds the time-domain signal. With a threshold of zero the output is the input delayed by three samples.

The threshold arrives precomputed on a plain input, `thr_level`. It would normally hold a scaled median-of-magnitudes noise estimate. The `flush` pulse empties all filter history between independent recordings. Both stream sides use a valid/ready handshake. One output register sits between the filters and the output port. A new sample is accepted only when that register is empty or is being drained in the same cycle, so output back-pressure reaches the input with no extra buffering. While `out_valid` is high and `out_ready` is low, `out_data` stays fixed and `in_ready` is low. Data is never dropped except by `flush`.

Top module: `wl_denoise_top`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1, and every filter history register is zero.
- R2: `in_ready` is 1 exactly when `flush` is 0 and either `out_valid` is 0 or `out_ready` is 1. While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_data` hold their values.
- R3: Each accepted sample (`in_valid` and `in_ready` both 1 at a clock edge) loads exactly one output word, and `out_valid` is 1 in the next cycle. Without an accepted sample, a consumed output leaves `out_valid` at 0.
- R4: With `thr_level` = 0, the output word produced by sample k, for k >= 4 counted from reset or flush, is within 4 LSB of sample k-3.
- R5: Accepted samples alternate even/odd, starting even after reset or flush. On each odd sample, with window w0 = that sample, w1 = the preceding even sample, w2 and w3 = the odd and even samples of the previous pair, lo = sum(Lk*wk) and hi = sum(Gk*wk). The low taps L0..L3 are 7913, 13705, 3672, -2120 (Q1.14). The high taps are G0 = L3, G1 = -L2, G2 = L1, G3 = -L0.
- R6: Hard threshold: a high-band coefficient whose magnitude is strictly below `thr_level` (unsigned) becomes 0. A coefficient whose magnitude equals or exceeds it is kept unchanged. Low-band coefficients are never modified.
- R7: Reconstruction: with (lp, hp) the previous pair's coefficients and (lc, hc) the current pair's, the odd sample's output word is L1*lp + G1*hp + L3*lc + G3*hc. The value L0*lp + G0*hp + L2*lc + G2*hc is kept and becomes the output word of the next even sample. An even sample right after reset or flush outputs 0.
- R8: Every filter sum is rounded by adding 8192 and shifting right arithmetically by 14. Coefficients saturate to a width of W+1 bits and output words saturate to W bits (-32768..32767 for W = 16).
- R9: While `flush` is 1, `in_ready` is 0. In the next cycle `out_valid` is 0 even if a word was waiting, and all history, stored coefficients, the pending word and the even/odd phase are cleared.
- R10: With `thr_level` at its maximum, the high band is removed (except coefficients of magnitude at least that value), so the output follows the low band alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Clears filter history and any pending output |
| thr_level | input | W | Unsigned hard-threshold level for the high band |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can accept a sample this cycle |
| in_data | input | W | Signed input sample |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Consumer takes the output word this cycle |
| out_data | output | W | Signed denoised sample |

## Verification
The bench uses an impulse whose high-band coefficient has magnitude exactly 129 and runs it with thresholds 129 and 130. A design that compares with less-or-equal, or that thresholds the low band, gives the wrong result in one of the two runs. Random output stalls check that a word under back-pressure is neither lost nor repeated. A design that accepts input while stalled would overwrite `out_data`. Full-scale alternating input drives the rounding and saturation limits, where wrapping instead of clamping gives a sign-flipped output. A flush taken while a word is waiting, followed by a constant stream, shows any history left behind as a wrong warm-up output.

// File: rtl/wl_pkg.sv
package wl_pkg;
  localparam int TAP_W  = 16;
  localparam int FRAC_W = 14;
  localparam int NTAP   = 4;

  typedef logic signed [TAP_W-1:0] tap_t;

  // Low-pass analysis taps in Q1.14: s, s*a0, -s*a0*a1, s*a1 with
  // s = 0.483, a0 = 1.732, a1 = -0.268.
  localparam tap_t LO_TAP [NTAP] = '{16'sd7913, 16'sd13705, 16'sd3672, -16'sd2120};

  // Quadrature mirror: reverse the low taps and negate every odd index.
  function automatic tap_t hi_tap(input int k);
    tap_t t;
    t = LO_TAP[NTAP-1-k];
    return (k % 2 == 0) ? t : -t;
  endfunction
endpackage

// File: rtl/wl_round_sat.sv
module wl_round_sat
  import wl_pkg::*;
#(
  parameter int IW = 34,
  parameter int OW = 16
) (
  input  logic signed [IW-1:0] acc,
  output logic signed [OW-1:0] q
);
  localparam int EW = IW + 1;
  localparam logic signed [EW-1:0] HALF = EW'(2 ** (FRAC_W - 1));
  localparam logic signed [EW-1:0] QMAX = {{(EW-OW+1){1'b0}}, {(OW-1){1'b1}}};
  localparam logic signed [EW-1:0] QMIN = ~QMAX;

  logic signed [EW-1:0] biased;
  logic signed [EW-1:0] shifted;

  // R8: round half up, then drop the fraction
  assign biased  = {acc[IW-1], acc} + HALF;
  assign shifted = biased >>> FRAC_W;

  always_comb begin
    if (shifted > QMAX)      q = QMAX[OW-1:0];
    else if (shifted < QMIN) q = QMIN[OW-1:0];
    else                     q = shifted[OW-1:0];
  end
endmodule

// File: rtl/wl_analysis.sv
module wl_analysis
  import wl_pkg::*;
#(
  parameter int W  = 16,
  parameter int CW = 17
) (
  input  logic [NTAP-1:0][W-1:0] win,
  output logic signed [CW-1:0]   lo_q,
  output logic signed [CW-1:0]   hi_q
);
  localparam int AW = W + TAP_W + 2;

  logic signed [AW-1:0] lo_prod [NTAP];
  logic signed [AW-1:0] hi_prod [NTAP];
  logic signed [AW-1:0] lo_acc;
  logic signed [AW-1:0] hi_acc;

  for (genvar k = 0; k < NTAP; k++) begin : g_tap
    logic signed [AW-1:0] xs;
    assign xs         = AW'($signed(win[k]));
    assign lo_prod[k] = xs * AW'(LO_TAP[k]);
    assign hi_prod[k] = xs * AW'(hi_tap(k));
  end

  always_comb begin
    lo_acc = '0;
    hi_acc = '0;
    for (int k = 0; k < NTAP; k++) begin
      lo_acc = lo_acc + lo_prod[k];
      hi_acc = hi_acc + hi_prod[k];
    end
  end

  wl_round_sat #(.IW(AW), .OW(CW)) u_rs_lo (.acc(lo_acc), .q(lo_q));
  wl_round_sat #(.IW(AW), .OW(CW)) u_rs_hi (.acc(hi_acc), .q(hi_q));
endmodule

// File: rtl/wl_hard_thresh.sv
module wl_hard_thresh #(
  parameter int W  = 16,
  parameter int CW = 17
) (
  input  logic signed [CW-1:0] coef,
  input  logic [W-1:0]         thr,
  output logic signed [CW-1:0] kept
);
  logic signed [CW:0] ext;
  logic [CW:0]        mag;
  logic [CW:0]        thr_ext;

  assign ext     = {coef[CW-1], coef};
  assign mag     = (ext < 0) ? unsigned'(-ext) : unsigned'(ext);
  assign thr_ext = (CW+1)'(thr);
  assign kept    = (mag < thr_ext) ? '0 : coef;

  // R6: a surviving coefficient is untouched and never below the level
  always_comb begin
    assert_keep_or_zero_R6: assert (kept == '0 || (kept == coef && mag >= thr_ext));
  end
endmodule

// File: rtl/wl_synthesis.sv
module wl_synthesis
  import wl_pkg::*;
#(
  parameter int W  = 16,
  parameter int CW = 17
) (
  input  logic signed [CW-1:0] lo_prev,
  input  logic signed [CW-1:0] hi_prev,
  input  logic signed [CW-1:0] lo_cur,
  input  logic signed [CW-1:0] hi_cur,
  output logic signed [W-1:0]  y_even,
  output logic signed [W-1:0]  y_odd
);
  localparam int AW = CW + TAP_W + 2;

  logic signed [W-1:0] y_r [2];

  // r = 0 rebuilds the older (even) sample, r = 1 the odd one (R7)
  for (genvar r = 0; r < 2; r++) begin : g_out
    logic signed [AW-1:0] acc;
    assign acc = AW'(lo_prev) * AW'(LO_TAP[1-r])
               + AW'(hi_prev) * AW'(hi_tap(1-r))
               + AW'(lo_cur)  * AW'(LO_TAP[3-r])
               + AW'(hi_cur)  * AW'(hi_tap(3-r));
    wl_round_sat #(.IW(AW), .OW(W)) u_rs (.acc(acc), .q(y_r[r]));
  end

  assign y_even = y_r[0];
  assign y_odd  = y_r[1];
endmodule

// File: rtl/wl_denoise_top.sv
module wl_denoise_top
  import wl_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic [W-1:0] thr_level,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  localparam int CW = W + 1;

  logic                  odd_ph;
  logic [W-1:0]          x_even, x_m1, x_m2;
  logic signed [CW-1:0]  lo_p, hi_p;
  logic signed [W-1:0]   y_pend;
  logic [NTAP-1:0][W-1:0] win;
  logic signed [CW-1:0]  lo_c, hi_raw, hi_c;
  logic signed [W-1:0]   y_even, y_odd;
  logic                  fire;

  assign in_ready = (!out_valid || out_ready) && !flush;
  assign fire     = in_valid && in_ready;

  assign win[0] = in_data;
  assign win[1] = x_even;
  assign win[2] = x_m1;
  assign win[3] = x_m2;

  wl_analysis #(.W(W), .CW(CW)) u_ana (
    .win  (win),
    .lo_q (lo_c),
    .hi_q (hi_raw)
  );

  wl_hard_thresh #(.W(W), .CW(CW)) u_thr (
    .coef (hi_raw),
    .thr  (thr_level),
    .kept (hi_c)
  );

  wl_synthesis #(.W(W), .CW(CW)) u_syn (
    .lo_prev (lo_p),
    .hi_prev (hi_p),
    .lo_cur  (lo_c),
    .hi_cur  (hi_c),
    .y_even  (y_even),
    .y_odd   (y_odd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      odd_ph    <= 1'b0;
      x_even    <= '0;
      x_m1      <= '0;
      x_m2      <= '0;
      lo_p      <= '0;
      hi_p      <= '0;
      y_pend    <= '0;
      out_data  <= '0;
      out_valid <= 1'b0;
    end else if (flush) begin
      odd_ph    <= 1'b0;
      x_even    <= '0;
      x_m1      <= '0;
      x_m2      <= '0;
      lo_p      <= '0;
      hi_p      <= '0;
      y_pend    <= '0;
      out_data  <= '0;
      out_valid <= 1'b0;
    end else if (fire) begin
      out_valid <= 1'b1;
      odd_ph    <= ~odd_ph;
      if (!odd_ph) begin
        x_even   <= in_data;
        out_data <= y_pend;
      end else begin
        x_m1     <= in_data;
        x_m2     <= x_even;
        lo_p     <= lo_c;
        hi_p     <= hi_c;
        y_pend   <= y_odd;
        out_data <= y_even;
      end
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R2: a stalled word is held and blocks the input
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !flush) |=> (out_valid && $stable(out_data)));
  assert_block_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
  // R3: one word per accepted sample, none without one
  assert_emit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
  assert_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!(in_valid && in_ready) && out_ready) |=> !out_valid);
  // R9: flush empties the output and restarts the pairing
  assert_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!out_valid && !odd_ph));
  // R5: phase advances only on an accepted sample
  assert_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && !(in_valid && in_ready)) |=> $stable(odd_ph));
endmodule

// File: tb/wl_denoise_top_tb_top.sv
`timescale 1ns/100ps
module wl_denoise_top_tb_top;
  localparam int W = 16;
  localparam longint H0 = 7913, H1 = 13705, H2 = 3672, H3 = -2120;
  localparam longint G0 = H3, G1 = -H2, G2 = H1, G3 = -H0;

  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0, in_valid = 1'b0, out_ready = 1'b1;
  logic [W-1:0] thr_level = '0, in_data = '0;
  logic in_ready, out_valid;
  logic [W-1:0] out_data;

  always #2.5 clk = ~clk;

  wl_denoise_top #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush), .thr_level(thr_level),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  int total = 0, bad = 0, obs_idx = 0;
  bit done = 0, tol_on = 0, stall_on = 0;
  string cur_tag = "R7";
  longint expq[$];
  string  tagq[$];
  longint in_hist[$];
  longint m_xe = 0, m_m1 = 0, m_m2 = 0, m_lop = 0, m_hip = 0, m_pend = 0;
  bit m_ph = 0;

  function automatic longint rs(longint acc, int bits);
    longint r, mx, mn;
    r  = (acc + 8192) >>> 14;
    mx = (longint'(1) << (bits - 1)) - 1;
    mn = -mx - 1;
    if (r > mx) r = mx;
    if (r < mn) r = mn;
    return r;
  endfunction

  function automatic longint hard(longint c, longint t);
    longint m;
    m = (c < 0) ? -c : c;
    return (m < t) ? 0 : c;
  endfunction

  function automatic longint sx(logic [W-1:0] v);
    return longint'($signed(v));
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic model_clear();
    m_xe = 0; m_m1 = 0; m_m2 = 0; m_lop = 0; m_hip = 0; m_pend = 0; m_ph = 0;
  endtask

  // Reference from R5..R8, pushed when the sample is accepted
  task automatic model_push(longint x);
    longint lo, hi, ye;
    in_hist.push_back(x);
    if (!m_ph) begin
      expq.push_back(m_pend);
      m_xe = x;
    end else begin
      lo = rs(H0*x + H1*m_xe + H2*m_m1 + H3*m_m2, W+1);
      hi = hard(rs(G0*x + G1*m_xe + G2*m_m1 + G3*m_m2, W+1), longint'(thr_level));
      ye = rs(H1*m_lop + G1*m_hip + H3*lo + G3*hi, W);
      m_pend = rs(H0*m_lop + G0*m_hip + H2*lo + G2*hi, W);
      expq.push_back(ye);
      m_m1 = x; m_m2 = m_xe; m_lop = lo; m_hip = hi;
    end
    tagq.push_back(cur_tag);
    m_ph = ~m_ph;
  endtask

  task automatic send(longint x);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = x[W-1:0];
    forever begin
      out_ready = stall_on ? ($urandom_range(2, 0) != 0) : 1'b1;
      #1;
      if (in_ready) break;
      @(negedge clk);
    end
    model_push(x);
  endtask

  task automatic drain();
    @(negedge clk);
    in_valid  = 1'b0;
    out_ready = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk(expq.size() == 0, "R3 one output per accepted sample", expq.size(), 0);
  endtask

  task automatic do_flush();
    @(negedge clk);
    in_valid = 1'b0;
    flush    = 1'b1;
    #1;
    chk(in_ready == 1'b0, "R9 in_ready low during flush", in_ready, 0);
    @(negedge clk);
    flush = 1'b0;
    #1;
    chk(out_valid == 1'b0, "R9 out_valid cleared by flush", out_valid, 0);
    expq.delete(); tagq.delete(); in_hist.delete();
    obs_idx = 0;
    model_clear();
  endtask

  // Monitor: compares each consumed word with the scoreboard
  initial begin
    longint e, d;
    string t;
    forever begin
      @(negedge clk);
      #1.5;
      if (rst_n && out_valid && out_ready) begin
        if (expq.size() == 0) begin
          chk(0, "R3 output without accepted sample", sx(out_data), 0);
        end else begin
          e = expq.pop_front();
          t = tagq.pop_front();
          chk(sx(out_data) == e, t, sx(out_data), e);
          if (tol_on && obs_idx >= 4 && obs_idx - 3 < in_hist.size()) begin
            d = sx(out_data) - in_hist[obs_idx-3];
            chk(d <= 4 && d >= -4, "R4 reconstruction within 4 LSB",
                sx(out_data), in_hist[obs_idx-3]);
          end
          obs_idx++;
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    longint held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R1 out_valid low after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R1 in_ready high after reset", in_ready, 1);

    // R4 R7: smooth triangle with threshold 0
    tol_on = 1; cur_tag = "R7 triangle stream";
    for (int i = 0; i < 48; i++) send(longint'((i * 700) % 9000) - 4000);
    drain();

    // R2: directed stall
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_data = 16'd1234;
    #1;
    chk(in_ready == 1'b1, "R2 in_ready with empty output", in_ready, 1);
    model_push(1234);
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    chk(out_valid == 1'b1, "R3 word after accept", out_valid, 1);
    chk(in_ready == 1'b0, "R2 in_ready low while stalled", in_ready, 0);
    held = sx(out_data);
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == 1'b1 && sx(out_data) == held, "R2 word held under stall", sx(out_data), held);
    out_ready = 1'b1;

    // R2 R5: random back-pressure
    cur_tag = "R5 random data with stalls"; stall_on = 1;
    for (int i = 0; i < 64; i++) send(longint'($urandom_range(16000, 0)) - 8000);
    stall_on = 0;
    drain();
    do_flush();

    // R6: impulse gives a high-band coefficient of magnitude 129
    tol_on = 0; thr_level = 16'd129; cur_tag = "R6 equal magnitude kept";
    for (int i = 0; i < 8; i++) send(i == 1 ? 1000 : 0);
    drain();
    do_flush();
    thr_level = 16'd130; cur_tag = "R6 below level zeroed";
    for (int i = 0; i < 8; i++) send(i == 1 ? 1000 : 0);
    drain();
    do_flush();

    // R10: maximum level removes the high band
    thr_level = '1; cur_tag = "R10 low band only";
    for (int i = 0; i < 32; i++) send(longint'($urandom_range(20000, 0)) - 10000);
    drain();
    do_flush();

    // R8: full-scale patterns
    thr_level = '0; cur_tag = "R8 rounding and saturation";
    for (int i = 0; i < 24; i++) send((i % 2) ? -32768 : 32767);
    for (int i = 0; i < 8; i++) send(32767);
    drain();

    // R9: flush while a word is waiting
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_data = 16'd500;
    #1;
    model_push(500);
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    chk(out_valid == 1'b1, "R9 word pending before flush", out_valid, 1);
    do_flush();
    out_ready = 1'b1;

    cur_tag = "R9 history cleared after flush";
    for (int i = 0; i < 16; i++) send(3000);
    drain();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule